// File: doc/BRIEF.md
# DRAM Refresh Scheduler with Postponement Credits

This block decides when a DDR SDRAM controller should spend a command slot on an AUTO REFRESH. A programmable down-counting timer creates one refresh obligation per interval (given in clock cycles). The obligations pile up in a credit counter, so the command arbiter can put refreshes off while it is busy with other traffic. The refresh command needs no address, because the memory picks its refresh rows itself. This block therefore produces only the timing decision.

Two request levels go to the arbiter. A normal request means at least one refresh is owed and may be taken at leisure. An urgent request means postponement must end now. It is raised when the credit count reaches its ceiling, or when a separate gap watchdog finds that the time since the last granted refresh is one interval short of the largest gap the memory tolerates. That largest gap is nine intervals, or eight in the strict-compliance variant. The arbiter answers with a one-cycle grant for each refresh it issues. Deasserting the enable input parks the whole scheduler.

Top module: `refresh_sched`

## Requirements
- R1: A synchronous active-high reset clears the interval timer, the credit count and the gap watchdog. Both requests are low in the cycle after a reset edge, and the first credit then appears after a full interval.
- R2: With enable high and an interval of N cycles, a credit is added at the N-th enabled clock edge and every N edges after that. The normal request is high exactly when the credit count is nonzero.
- R3: The credit count saturates at 8 and never wraps. After more than eight intervals without a grant, exactly eight grants are needed to clear the normal request.
- R4: A grant taken while credits are owed removes one credit. A grant on the same edge as a timer expiry leaves the count unchanged.
- R5: The urgent request rises when the credit count reaches 8 (STRICT=0) or 7 (STRICT=1), and only while the normal request is high.
- R6: The gap watchdog counts enabled cycles since the last accepted grant. It raises the urgent request once that count reaches 8×N (STRICT=0) or 7×N (STRICT=1), even when few credits are owed. An accepted grant restarts it.
- R7: While enable is low, the timer, credit count and watchdog are held at zero and both requests are low. After enable returns, the first credit needs a full interval.
- R8: A grant while no credit is owed has no effect on the count.
- R9: An arbiter that grants only on the urgent request never sees more than 9×N cycles between consecutive grants.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| enable | input | 1 | Runs the scheduler; low parks and clears it |
| intervalCycles | input | IW | Average refresh interval in clock cycles |
| refGrant | input | 1 | Arbiter issued a refresh this cycle |
| refReq | output | 1 | At least one refresh credit is owed |
| refUrgent | output | 1 | Refresh must not be postponed further |

## Verification
All state sits in registers, and both requests are decoded from that state combinationally. A grant or a timer expiry at one clock edge therefore shows on the requests just after that same edge. The exception is a change of the interval input, which reaches the watchdog threshold within the same cycle. The bench drives inputs on the falling edge and counts rising edges from the cycle enable was applied: an interval of N gives a first request after N edges and an urgent after 8N. It samples just before the following falling edge, on both sides of every boundary (N-1 and N, 7N and 8N, seven and eight grants). The tick-plus-grant case is placed on an edge known to carry an expiry.

// File: rtl/refresh_sched_pkg.sv
package refresh_sched_pkg;
  // Strobes from the control half to the counters
  typedef struct packed {
    logic run;         // timer advances this cycle
    logic clear;       // park all counters at zero
    logic incPend;     // add one refresh credit
    logic decPend;     // remove one refresh credit
    logic restartGap;  // accepted grant: restart the gap watchdog
  } refStrobes_t;
endpackage

// File: rtl/refresh_sched_dp.sv
module refresh_sched_dp
  import refresh_sched_pkg::*;
#(
  parameter int IW = 16,
  parameter int CW = 4,
  parameter int GW = 20
) (
  input  logic          clk,
  input  logic          rst,
  input  refStrobes_t   strb,
  input  logic [IW-1:0] intervalCycles,
  output logic          tick,
  output logic [CW-1:0] pendCount,
  output logic [GW-1:0] gapCount
);
  localparam logic [GW-1:0] GAP_MAX = '1;

  logic [IW-1:0] elapsed;

  // Expiry when the next count would reach the interval (0 or 1 means every cycle)
  assign tick = strb.run && (({1'b0, elapsed} + (IW+1)'(1)) >= {1'b0, intervalCycles});

  always_ff @(posedge clk) begin
    if (rst || strb.clear) begin
      elapsed <= '0;
    end else if (tick) begin
      elapsed <= '0;
    end else if (strb.run) begin
      elapsed <= elapsed + IW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst || strb.clear) begin
      pendCount <= '0;
    end else if (strb.incPend && !strb.decPend) begin
      pendCount <= pendCount + CW'(1);
    end else if (strb.decPend && !strb.incPend) begin
      pendCount <= pendCount - CW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst || strb.clear) begin
      gapCount <= '0;
    end else if (strb.restartGap) begin
      gapCount <= '0;
    end else if (strb.run && gapCount != GAP_MAX) begin
      gapCount <= gapCount + GW'(1);
    end
  end
endmodule

// File: rtl/refresh_sched_ctrl.sv
module refresh_sched_ctrl
  import refresh_sched_pkg::*;
#(
  parameter int IW         = 16,
  parameter int CW         = 4,
  parameter int GW         = 20,
  parameter int MAX_CREDIT = 8,
  parameter bit STRICT     = 1'b0
) (
  input  logic          enable,
  input  logic          refGrant,
  input  logic [IW-1:0] intervalCycles,
  input  logic          tick,
  input  logic [CW-1:0] pendCount,
  input  logic [GW-1:0] gapCount,
  output refStrobes_t   strb,
  output logic          refReq,
  output logic          refUrgent
);
  localparam int URG_LEVEL = STRICT ? MAX_CREDIT - 1 : MAX_CREDIT;
  localparam int WD_MULT   = STRICT ? MAX_CREDIT - 1 : MAX_CREDIT;

  logic          owed;
  logic          full;
  logic          grantOk;
  logic          creditHot;
  logic          gapHot;
  logic [GW-1:0] gapLimit;

  assign owed      = pendCount != '0;
  assign full      = pendCount == CW'(MAX_CREDIT);
  assign grantOk   = enable && refGrant && owed;
  assign creditHot = pendCount >= CW'(URG_LEVEL);
  assign gapLimit  = GW'({{(GW-IW){1'b0}}, intervalCycles}) * GW'(WD_MULT);
  assign gapHot    = gapCount >= gapLimit;

  always_comb begin
    strb            = '0;
    strb.run        = enable;
    strb.clear      = !enable;
    strb.decPend    = grantOk;
    strb.incPend    = tick && (!full || grantOk);
    strb.restartGap = grantOk;
  end

  assign refReq    = enable && owed;
  assign refUrgent = refReq && (creditHot || gapHot);
endmodule

// File: rtl/refresh_sched.sv
module refresh_sched
  import refresh_sched_pkg::*;
#(
  parameter int IW         = 16,
  parameter int MAX_CREDIT = 8,
  parameter bit STRICT     = 1'b0,
  localparam int CW        = $clog2(MAX_CREDIT + 1),
  localparam int GW        = IW + $clog2(MAX_CREDIT + 2) + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          enable,
  input  logic [IW-1:0] intervalCycles,
  input  logic          refGrant,
  output logic          refReq,
  output logic          refUrgent
);
  refStrobes_t   strb;
  logic          timerTick;
  logic [CW-1:0] pendCount;
  logic [GW-1:0] gapCount;

  refresh_sched_dp #(.IW(IW), .CW(CW), .GW(GW)) u_dp (
    .clk(clk), .rst(rst), .strb(strb), .intervalCycles(intervalCycles),
    .tick(timerTick), .pendCount(pendCount), .gapCount(gapCount)
  );

  refresh_sched_ctrl #(.IW(IW), .CW(CW), .GW(GW), .MAX_CREDIT(MAX_CREDIT), .STRICT(STRICT)) u_ctrl (
    .enable(enable), .refGrant(refGrant), .intervalCycles(intervalCycles),
    .tick(timerTick), .pendCount(pendCount), .gapCount(gapCount),
    .strb(strb), .refReq(refReq), .refUrgent(refUrgent)
  );
endmodule

// File: rtl/refresh_sched_chk.sv
module refresh_sched_chk #(
  parameter int MAX_CREDIT = 8,
  parameter int CW         = 4
) (
  input logic          clk,
  input logic          rst,
  input logic          enable,
  input logic          refGrant,
  input logic          refReq,
  input logic          refUrgent,
  input logic [CW-1:0] pendCount,
  input logic          tick
);
  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (pendCount == '0 && !refReq && !refUrgent));

  a_r3_bounded: assert property (@(posedge clk) disable iff (rst)
    pendCount <= CW'(MAX_CREDIT));

  a_r3_no_wrap: assert property (@(posedge clk) disable iff (rst)
    (enable && !refGrant && pendCount == CW'(MAX_CREDIT)) |=> pendCount == CW'(MAX_CREDIT));

  a_r2_single_step: assert property (@(posedge clk) disable iff (rst)
    ({1'b0, pendCount} <= {1'b0, $past(pendCount)} + (CW+1)'(1)));

  a_r4_grant_decrements: assert property (@(posedge clk) disable iff (rst)
    (enable && refGrant && pendCount != '0 && !tick) |=> (pendCount + CW'(1)) == $past(pendCount));

  a_r5_urgent_needs_req: assert property (@(posedge clk) disable iff (rst)
    refUrgent |-> refReq);

  a_r7_idle_when_off: assert property (@(posedge clk) disable iff (rst)
    !enable |-> (!refReq && !refUrgent));

  a_r7_cleared_when_off: assert property (@(posedge clk) disable iff (rst)
    !enable |=> pendCount == '0);
endmodule

bind refresh_sched refresh_sched_chk #(.MAX_CREDIT(MAX_CREDIT), .CW(CW)) u_chk (
  .clk(clk), .rst(rst), .enable(enable), .refGrant(refGrant),
  .refReq(refReq), .refUrgent(refUrgent), .pendCount(pendCount), .tick(timerTick)
);

// File: tb/refresh_sched_tb.sv
module refresh_sched_tb;
  logic        clk = 1'b0;
  logic        rst;
  logic        enable;
  logic [15:0] intervalCycles;
  logic        refGrant;
  logic        refReq, refUrgent;
  logic        sReq, sUrgent;

  int checks   = 0;
  int failures = 0;

  always #10 clk = ~clk;  // 50 MHz

  refresh_sched #(.IW(16), .MAX_CREDIT(8), .STRICT(1'b0)) u_dut (
    .clk(clk), .rst(rst), .enable(enable), .intervalCycles(intervalCycles),
    .refGrant(refGrant), .refReq(refReq), .refUrgent(refUrgent)
  );

  refresh_sched #(.IW(16), .MAX_CREDIT(8), .STRICT(1'b1)) u_dutStrict (
    .clk(clk), .rst(rst), .enable(enable), .intervalCycles(intervalCycles),
    .refGrant(refGrant), .refReq(sReq), .refUrgent(sUrgent)
  );

  task automatic check(string req, string what, logic actual, logic expected);
    checks++;
    if (actual !== expected) begin
      failures++;
      $display("FAIL %s %s: actual=%0b expected=%0b", req, what, actual, expected);
    end
  endtask

  task automatic waitN(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic doReset(logic [15:0] iv);
    @(negedge clk);
    rst = 1'b1; enable = 1'b0; refGrant = 1'b0; intervalCycles = iv;
    waitN(2);
    rst = 1'b0;
  endtask

  task automatic testR1();
    doReset(16'd10);
    check("R1", "req after reset", refReq, 1'b0);
    check("R1", "urgent after reset", refUrgent, 1'b0);
    enable = 1'b1;
    waitN(100);
    check("R1", "urgent before reset", refUrgent, 1'b1);
    rst = 1'b1;
    waitN(1);
    rst = 1'b0;
    check("R1", "req cleared by reset", refReq, 1'b0);
    check("R1", "urgent cleared by reset", refUrgent, 1'b0);
    waitN(9);
    check("R1", "no credit before full interval", refReq, 1'b0);
    waitN(1);
    check("R1", "credit after full interval", refReq, 1'b1);
  endtask

  task automatic testR2();
    doReset(16'd10);
    enable = 1'b1;
    waitN(9);
    check("R2", "req at N-1", refReq, 1'b0);
    waitN(1);
    check("R2", "req at N", refReq, 1'b1);
    check("R2", "urgent at N", refUrgent, 1'b0);
  endtask

  task automatic testR3();
    doReset(16'd10);
    enable = 1'b1;
    waitN(100);  // ten expiries, last on edge 100
    refGrant = 1'b1;
    waitN(1);
    check("R5", "urgent drops below 8", refUrgent, 1'b0);
    waitN(6);
    check("R3", "req after 7 grants", refReq, 1'b1);
    waitN(1);
    refGrant = 1'b0;
    check("R3", "req after 8 grants", refReq, 1'b0);
    check("R3", "strict req after 8 grants", sReq, 1'b0);
  endtask

  task automatic testR4();
    doReset(16'd10);
    enable = 1'b1;
    waitN(19);
    refGrant = 1'b1;
    waitN(1);  // edge 20: expiry and grant together
    check("R4", "req after tick+grant", refReq, 1'b1);
    waitN(1);  // edge 21: grant alone
    refGrant = 1'b0;
    check("R4", "one credit left after tick+grant", refReq, 1'b0);
  endtask

  task automatic testR5();
    doReset(16'd10);
    enable = 1'b1;
    waitN(69);
    check("R5", "strict urgent at 6 credits", sUrgent, 1'b0);
    waitN(1);
    check("R5", "strict urgent at 7 credits", sUrgent, 1'b1);
    check("R5", "urgent at 7 credits", refUrgent, 1'b0);
    waitN(9);
    check("R5", "urgent just before 8 credits", refUrgent, 1'b0);
    waitN(1);
    check("R5", "urgent at 8 credits", refUrgent, 1'b1);
  endtask

  task automatic testR6();
    doReset(16'd100);
    enable = 1'b1;
    waitN(150);  // one credit, gap 150
    check("R6", "no urgent with long interval", refUrgent, 1'b0);
    intervalCycles = 16'd10;  // threshold falls to 80
    waitN(1);  // expiry -> two credits
    check("R6", "watchdog urgent with 2 credits", refUrgent, 1'b1);
    check("R6", "strict watchdog urgent", sUrgent, 1'b1);
    refGrant = 1'b1;
    waitN(1);
    refGrant = 1'b0;
    check("R6", "grant restarts watchdog", refUrgent, 1'b0);
    check("R6", "credit still owed", refReq, 1'b1);
  endtask

  task automatic testR7();
    doReset(16'd10);
    enable = 1'b1;
    waitN(15);
    check("R7", "req before disable", refReq, 1'b1);
    enable = 1'b0;
    waitN(1);
    check("R7", "req while disabled", refReq, 1'b0);
    for (int i = 0; i < 20; i++) begin
      refGrant = i[0];
      waitN(1);
    end
    refGrant = 1'b0;
    check("R7", "req stays low while disabled", refReq, 1'b0);
    check("R7", "urgent low while disabled", refUrgent, 1'b0);
    enable = 1'b1;
    waitN(9);
    check("R7", "no credit before full interval", refReq, 1'b0);
    waitN(1);
    check("R7", "credit after full interval", refReq, 1'b1);
  endtask

  task automatic testR8();
    doReset(16'd10);
    enable = 1'b1;
    refGrant = 1'b1;
    waitN(9);
    refGrant = 1'b0;
    waitN(1);
    check("R8", "credit counted despite early grants", refReq, 1'b1);
    refGrant = 1'b1;
    waitN(1);
    refGrant = 1'b0;
    check("R8", "exactly one credit owed", refReq, 1'b0);
  endtask

  task automatic testR9();
    int gap = 0;
    int maxGap = 0;
    int grants = 0;
    doReset(16'd10);
    enable = 1'b1;
    for (int i = 0; i < 400; i++) begin
      refGrant = refUrgent;
      waitN(1);
      gap++;
      if (refGrant) begin
        grants++;
        if (gap > maxGap) maxGap = gap;
        gap = 0;
      end
    end
    refGrant = 1'b0;
    checks++;
    if (grants == 0 || maxGap > 90) begin
      failures++;
      $display("FAIL R9 gap limit: actual=%0d grants=%0d expected max<=90", maxGap, grants);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst = 1'b1; enable = 1'b0; refGrant = 1'b0; intervalCycles = 16'd10;
    testR1();
    testR2();
    testR3();
    testR4();
    testR5();
    testR6();
    testR7();
    testR8();
    testR9();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule